// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Summary Word

This block collects 72 level-sensitive interrupt lines and presents them to one processor through a 32-bit register port. The lines are split into a basic group of 8 and two peripheral banks of 32. Each group has its own enable mask. Software sets mask bits by writing ones to an enable word and clears them by writing ones to a disable word, so no read-modify-write is needed. A source counts as pending only while its line is high and its enable bit is set. Nothing is latched, so the pending state follows the line.

Pending state is read at two levels. Each bank has a word that shows its pending sources in full. A summary word holds the basic pending bits, direct copies of a few chosen bank bits, and one flag per bank. The flag says that some other source in that bank is pending. An interrupt handler reads the summary word first. It reads a bank word only when that bank's flag is set. One registered IRQ output tells the processor that any source is pending.

Top module: `irq_summary_ctrl`

## Requirements
- R1: Summary word (word address 0) bits 7:0 equal basic line AND basic enable, bit by bit.
- R2: Bank pending words (address 1 for bank 1, address 2 for bank 2) read line AND enable for all 32 sources. No bit is latched: dropping a line or its enable clears the bit at once.
- R3: Summary bit 8 is set when any pending bank-1 source without a shortcut is set. Summary bit 9 does the same for bank 2.
- R4: Summary bits 14:10 copy the pending state of bank-1 positions 7, 9, 10, 18 and 19, in that order. Bits 20:15 copy bank-2 positions 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read 0. The positions are parameters.
- R5: Writing to an enable word ORs the written ones into the mask. Writing to a disable word clears the masked bits that are written as one. Zero bits in the written data leave the mask unchanged.
- R6: Enable words sit at addresses 4, 5 and 6, and disable words at 8, 9 and 10, in the order bank 1, bank 2, basic. A read of either word of a group returns that group's current enable mask. A write changes only its own group.
- R7: After reset all enable masks are 0 and the IRQ output is 0.
- R8: The IRQ output equals the OR of all pending sources, registered, one clock after the lines or masks change.
- R9: Addresses 3, 7 and 11 to 15 read as 0. Writes to them change no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| src_basic_i | input | 8 | Basic interrupt lines |
| src_bank1_i | input | 32 | Bank 1 interrupt lines |
| src_bank2_i | input | 32 | Bank 2 interrupt lines |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The checker verifies on every cycle:
- enable words set and disable words clear the written bits;
- a mask changes only when its own words are written;
- bank pending reads never show a disabled bit;
- a raised summary flag is backed by a pending bank source;
- the IRQ output trails the pending OR by one clock;
- unmapped addresses read 0.

Only the bench scenarios show the rest:
- which shortcut position feeds which summary bit;
- that shortcut sources are kept out of the bank flags;
- that pending state is not latched;
- that writes to unmapped addresses leave every mask unchanged.

The bench drives each of the 72 lines alone, then mixes random masks and lines, and compares against a model built from these requirements.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int POS_W  = 5;
  localparam int SC1_N  = 5;
  localparam int SC2_N  = 6;
  localparam int SUM_FLAG1 = 8;
  localparam int SUM_FLAG2 = 9;
  localparam int SUM_SC1_LO = 10;
  localparam int SUM_SC2_LO = SUM_SC1_LO + SC1_N;

  localparam logic [ADDR_W-1:0] A_SUMMARY  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PEND_B1  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PEND_B2  = 4'd2;
  localparam logic [ADDR_W-1:0] A_EN_BASE  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DIS_BASE = 4'd8;

  // group index: 0 bank1, 1 bank2, 2 basic
  localparam int G_B1    = 0;
  localparam int G_B2    = 1;
  localparam int G_BASIC = 2;
endpackage

// File: rtl/irqs_en_reg.sv
module irqs_en_reg
  import irqs_pkg::*;
#(
  parameter int W   = 32,
  parameter int IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      en_o
);
  localparam logic [ADDR_W-1:0] SET_ADDR = A_EN_BASE  + ADDR_W'(IDX);
  localparam logic [ADDR_W-1:0] CLR_ADDR = A_DIS_BASE + ADDR_W'(IDX);

  logic set_hit, clr_hit;
  assign set_hit = wr_i && (addr_i == SET_ADDR);
  assign clr_hit = wr_i && (addr_i == CLR_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (set_hit) en_o <= en_o | wdata_i;
    else if (clr_hit) en_o <= en_o & ~wdata_i;
  end
endmodule

// File: rtl/irqs_summary.sv
module irqs_summary
  import irqs_pkg::*;
#(
  parameter int BASIC_W = 8,
  parameter int BANK_W  = 32,
  parameter logic [SC1_N*POS_W-1:0] SC1_POS = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7},
  parameter logic [SC2_N*POS_W-1:0] SC2_POS = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21}
) (
  input  logic [BASIC_W-1:0] pend_basic_i,
  input  logic [BANK_W-1:0]  pend_b1_i,
  input  logic [BANK_W-1:0]  pend_b2_i,
  output logic [DATA_W-1:0]  sum_o
);
  logic [BANK_W-1:0] sc_mask1, sc_mask2;
  logic [SC1_N-1:0]  sc_bits1;
  logic [SC2_N-1:0]  sc_bits2;

  always_comb begin
    sc_mask1 = '0;
    for (int k = 0; k < SC1_N; k++) sc_mask1[SC1_POS[k*POS_W +: POS_W]] = 1'b1;
  end

  always_comb begin
    sc_mask2 = '0;
    for (int k = 0; k < SC2_N; k++) sc_mask2[SC2_POS[k*POS_W +: POS_W]] = 1'b1;
  end

  for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
    assign sc_bits1[k] = pend_b1_i[SC1_POS[k*POS_W +: POS_W]];
  end

  for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
    assign sc_bits2[k] = pend_b2_i[SC2_POS[k*POS_W +: POS_W]];
  end

  always_comb begin
    sum_o = '0;
    sum_o[BASIC_W-1:0] = pend_basic_i;
    sum_o[SUM_FLAG1]   = |(pend_b1_i & ~sc_mask1);
    sum_o[SUM_FLAG2]   = |(pend_b2_i & ~sc_mask2);
    sum_o[SUM_SC1_LO +: SC1_N] = sc_bits1;
    sum_o[SUM_SC2_LO +: SC2_N] = sc_bits2;
  end
endmodule

// File: rtl/irq_summary_ctrl.sv
module irq_summary_ctrl
  import irqs_pkg::*;
#(
  parameter int BASIC_W = 8,
  parameter int BANK_W  = 32,
  parameter logic [SC1_N*POS_W-1:0] SC1_POS = {5'd19, 5'd18, 5'd10, 5'd9, 5'd7},
  parameter logic [SC2_N*POS_W-1:0] SC2_POS = {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [BASIC_W-1:0] src_basic_i,
  input  logic [BANK_W-1:0]  src_bank1_i,
  input  logic [BANK_W-1:0]  src_bank2_i,
  output logic               irq_o
);
  localparam int NBANK = 2;

  logic [BANK_W-1:0]  bank_src [NBANK];
  logic [BANK_W-1:0]  bank_en  [NBANK];
  logic [BANK_W-1:0]  bank_pend[NBANK];
  logic [BASIC_W-1:0] en_basic_q, pend_basic;
  logic [BANK_W-1:0]  en_b1_q, en_b2_q;
  logic [DATA_W-1:0]  summary;
  logic               any_pend;

  assign bank_src[G_B1] = src_bank1_i;
  assign bank_src[G_B2] = src_bank2_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irqs_en_reg #(.W(BANK_W), .IDX(b)) u_en (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i[BANK_W-1:0]),
      .en_o    (bank_en[b])
    );
    assign bank_pend[b] = bank_src[b] & bank_en[b];
  end

  irqs_en_reg #(.W(BASIC_W), .IDX(G_BASIC)) u_en_basic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i[BASIC_W-1:0]),
    .en_o    (en_basic_q)
  );

  assign en_b1_q    = bank_en[G_B1];
  assign en_b2_q    = bank_en[G_B2];
  assign pend_basic = src_basic_i & en_basic_q;

  irqs_summary #(
    .BASIC_W (BASIC_W),
    .BANK_W  (BANK_W),
    .SC1_POS (SC1_POS),
    .SC2_POS (SC2_POS)
  ) u_sum (
    .pend_basic_i (pend_basic),
    .pend_b1_i    (bank_pend[G_B1]),
    .pend_b2_i    (bank_pend[G_B2]),
    .sum_o        (summary)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SUMMARY:                 rdata_o = summary;
      A_PEND_B1:                 rdata_o = DATA_W'(bank_pend[G_B1]);
      A_PEND_B2:                 rdata_o = DATA_W'(bank_pend[G_B2]);
      A_EN_BASE + 4'd0,
      A_DIS_BASE + 4'd0:         rdata_o = DATA_W'(en_b1_q);
      A_EN_BASE + 4'd1,
      A_DIS_BASE + 4'd1:         rdata_o = DATA_W'(en_b2_q);
      A_EN_BASE + 4'd2,
      A_DIS_BASE + 4'd2:         rdata_o = DATA_W'(en_basic_q);
      default:                   rdata_o = '0;
    endcase
  end

  assign any_pend = |pend_basic | |bank_pend[G_B1] | |bank_pend[G_B2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= any_pend;
  end
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk
  import irqs_pkg::*;
#(
  parameter int BASIC_W = 8,
  parameter int BANK_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [BASIC_W-1:0] src_basic_i,
  input logic [BANK_W-1:0]  src_bank1_i,
  input logic [BANK_W-1:0]  src_bank2_i,
  input logic               irq_o,
  input logic [BASIC_W-1:0] en_basic_q,
  input logic [BANK_W-1:0]  en_b1_q,
  input logic [BANK_W-1:0]  en_b2_q
);
  logic unmapped;
  assign unmapped = (addr_i == 4'd3) || (addr_i == 4'd7) || (addr_i > 4'd10);

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_EN_BASE) |=> ((en_b1_q & $past(wdata_i)) == $past(wdata_i))); // R5

  AST_DIS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DIS_BASE + 4'd1) |=> ((en_b2_q & $past(wdata_i)) == '0)); // R5

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_EN_BASE || addr_i == A_DIS_BASE)) |=> $stable(en_b1_q)); // R6

  AST_BASIC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_EN_BASE + 4'd2 || addr_i == A_DIS_BASE + 4'd2)) |=> $stable(en_basic_q)); // R6

  AST_PEND_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_PEND_B1) |-> ((rdata_o & ~DATA_W'(en_b1_q)) == '0)); // R2

  AST_FLAG_BACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SUMMARY && rdata_o[SUM_FLAG1]) |-> (|(src_bank1_i & en_b1_q))); // R3

  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(src_basic_i & en_basic_q) | |(src_bank1_i & en_b1_q)
                             | |(src_bank2_i & en_b2_q)))); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> (rdata_o == '0)); // R9
endmodule

bind irq_summary_ctrl irqs_chk #(.BASIC_W(BASIC_W), .BANK_W(BANK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .src_basic_i (src_basic_i),
  .src_bank1_i (src_bank1_i),
  .src_bank2_i (src_bank2_i),
  .irq_o       (irq_o),
  .en_basic_q  (en_basic_q),
  .en_b1_q     (en_b1_q),
  .en_b2_q     (en_b2_q)
);

// File: tb/sim_irq_summary_ctrl.sv
`timescale 1ns/1ps
module sim_irq_summary_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  s_basic = '0;
  logic [31:0] s_b1 = '0, s_b2 = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model enable masks: 0 bank1, 1 bank2, 2 basic
  logic [31:0] m_en [3];

  int pos1 [5] = '{7, 9, 10, 18, 19};
  int pos2 [6] = '{21, 22, 23, 24, 25, 30};

  always #2 clk = ~clk;

  irq_summary_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_basic_i(s_basic), .src_bank1_i(s_b1),
    .src_bank2_i(s_b2), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wrt(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a >= 4 && a <= 6)  m_en[a-4] = m_en[a-4] | d;
    if (a >= 8 && a <= 10) m_en[a-8] = m_en[a-8] & ~d;
    m_en[2] = m_en[2] & 32'hFF;
  endtask

  function automatic logic [31:0] exp_sum();
    logic [31:0] p1, p2, r, m1, m2;
    p1 = s_b1 & m_en[0];
    p2 = s_b2 & m_en[1];
    m1 = '0; m2 = '0; r = '0;
    r[7:0] = s_basic & m_en[2][7:0];
    for (int k = 0; k < 5; k++) begin r[10+k] = p1[pos1[k]]; m1[pos1[k]] = 1'b1; end
    for (int k = 0; k < 6; k++) begin r[15+k] = p2[pos2[k]]; m2[pos2[k]] = 1'b1; end
    r[8] = |(p1 & ~m1);
    r[9] = |(p2 & ~m2);
    return r;
  endfunction

  function automatic logic exp_irq();
    return |(s_basic & m_en[2][7:0]) | |(s_b1 & m_en[0]) | |(s_b2 & m_en[1]);
  endfunction

  task automatic check_all(input string ctx);
    logic [31:0] d;
    rd(4'd0, d); chk({ctx, " R1 R3 R4 summary"}, d, exp_sum());
    rd(4'd1, d); chk({ctx, " R2 bank1 pending"}, d, s_b1 & m_en[0]);
    rd(4'd2, d); chk({ctx, " R2 bank2 pending"}, d, s_b2 & m_en[1]);
    chk({ctx, " R8 irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic check_en(input string ctx);
    logic [31:0] d;
    for (int g = 0; g < 3; g++) begin
      rd(4'(4 + g), d); chk({ctx, " R6 enable read"}, d, m_en[g]);
      rd(4'(8 + g), d); chk({ctx, " R6 disable-word read"}, d, m_en[g]);
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unm [7] = '{3, 7, 11, 12, 13, 14, 15};
    for (int g = 0; g < 3; g++) m_en[g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    s_b1 = 32'hFFFF_FFFF; s_b2 = 32'hFFFF_FFFF; s_basic = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R7 irq after reset", {31'd0, irq}, 32'd0);
    check_en("R7 reset");
    check_all("R7 reset pend");
    s_b1 = '0; s_b2 = '0; s_basic = '0;

    // R5 enable all
    wrt(4'd4, 32'hFFFF_FFFF); wrt(4'd5, 32'hFFFF_FFFF); wrt(4'd6, 32'hFFFF_FFFF);
    check_en("R5 set all");

    // single-source sweep over all 72 lines: R1 R2 R3 R4 R8
    for (int i = 0; i < 72; i++) begin
      @(negedge clk);
      s_basic = '0; s_b1 = '0; s_b2 = '0;
      if (i < 8)       s_basic[i] = 1'b1;
      else if (i < 40) s_b1[i-8]  = 1'b1;
      else             s_b2[i-40] = 1'b1;
      @(negedge clk);
      check_all("sweep");
    end

    // R2 no latching: drop the line
    @(negedge clk); s_b1 = 32'h0000_0001; s_b2 = '0; s_basic = '0;
    @(negedge clk); check_all("R2 line high");
    @(negedge clk); s_b1 = '0;
    @(negedge clk); check_all("R2 line low");

    // R5 zero bits no effect, disable clears
    wrt(4'd8, 32'h0000_00F0); check_en("R5 partial disable");
    wrt(4'd8, 32'h0000_0000); check_en("R5 zero disable");
    wrt(4'd4, 32'h0000_0000); check_en("R5 zero enable");
    s_b1 = 32'h0000_00F0;
    @(negedge clk); check_all("R2 disabled line");

    // R9 unmapped addresses
    for (int u = 0; u < 7; u++) begin
      wrt(4'(unm[u]), 32'hFFFF_FFFF);
      wrt(4'(unm[u]), 32'h0000_0000);
      rd(4'(unm[u]), d); chk("R9 unmapped read", d, 32'd0);
    end
    check_en("R9 masks after unmapped writes");

    // random mix of mask writes and lines
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 5);
      wrt(op < 3 ? 4'(4 + op) : 4'(8 + op - 3), $urandom());
      @(negedge clk);
      s_b1 = $urandom() & $urandom();
      s_b2 = $urandom() & $urandom();
      s_basic = 8'($urandom());
      @(negedge clk);
      check_all("random");
      if (it % 20 == 0) check_en("R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule